// File: doc/BRIEF.md
# Vertical-First Element Stepper

This block keeps the pair of element positions (a source position and a destination position) that a vector unit uses while running in vertical-first mode. In that mode each vector instruction touches a single element, and the positions stay put from one instruction to the next. They move only when an explicit step command arrives. A step moves each position forward to the next element whose predicate bit is set, looking only at elements below the current vector length. When either position runs out of enabled elements, both positions go back to zero and an end-of-vector flag is raised.

Each step can also produce a 4-bit condition field and a returned value. A selector chooses what is reported. It can pick the end flags of one of four loop states, which are supplied from outside as inner, middle and outer end bits. It can also pick the new source or destination position as the value returned to the target register. Positions, the end flag, the condition field and the returned value are all registered, so every result appears one clock after the step is accepted.

Top module: `vfs_stepper`

## Requirements
- R1: While reset is asserted and after it is released, `src_idx`, `dst_idx`, `vec_end`, `cr_field`, `cr_valid`, `ret_valid` and `ret_value` are all zero.
- R2: A step is accepted only on a clock edge where `step_en=1`, `vf=1`, `vs=0` and `ms=0`. On every other edge `src_idx` and `dst_idx` keep their values.
- R3: On an accepted step, `src_idx` becomes the lowest position i with i greater than the old `src_idx`, i below `vl`, and `src_mask[i]=1`. `dst_idx` is found the same way from `dst_mask`, independently of the source search.
- R4: If either search in R3 finds no position, both indices become 0 and `vec_end` becomes 1. Otherwise `vec_end` becomes 0. A `vl` of 0 always gives this wrap. `vec_end` changes only on accepted steps.
- R5: `cr_valid` is high for exactly the one cycle after an accepted step with `rc=1`. In that cycle `cr_field` bits are [3]=LT, [2]=GT, [1]=EQ, [0]=SO, and SO equals the new `vec_end`.
- R6: For selector `sel` = 1..4, loop state k = sel-1 is read from `loop_end[3k+2:3k]`, where bit 3k is the inner end, bit 3k+1 is the middle end and bit 3k+2 is the outer end. These map to EQ=inner, LT=middle, GT=outer. For any other selector, LT, GT and EQ are 0.
- R7: `ret_valid` is high for exactly the one cycle after an accepted step with `rt_nz=1` and `sel` equal to 5 or 6. `ret_value` is then the new `src_idx` (sel 5) or the new `dst_idx` (sel 6), zero-extended. In every other case `ret_valid` stays 0.
- R8: `cr_field` and `ret_value` change only when their valid pulse is produced. A rejected step produces neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vl | input | 7 | Current vector length, 0 to 64 |
| src_mask | input | 64 | Source predicate, one bit per element |
| dst_mask | input | 64 | Destination predicate, one bit per element |
| step_en | input | 1 | Step command strobe |
| vf | input | 1 | Vertical-first flag of the command |
| vs | input | 1 | Length-select flag; must be 0 to step |
| ms | input | 1 | Max-length-select flag; must be 0 to step |
| sel | input | 3 | Selector immediate |
| rc | input | 1 | Request a condition-field update |
| rt_nz | input | 1 | Target register is nonzero |
| loop_end | input | 12 | Inner/middle/outer end flags for loop states 0..3 |
| src_idx | output | 6 | Current source element position |
| dst_idx | output | 6 | Current destination element position |
| vec_end | output | 1 | Last accepted step wrapped |
| cr_valid | output | 1 | One-cycle pulse: `cr_field` updated |
| cr_field | output | 4 | LT, GT, EQ, SO |
| ret_valid | output | 1 | One-cycle pulse: `ret_value` updated |
| ret_value | output | 64 | Returned position, zero-extended |

## Verification
The assertions assume that the command inputs are driven cleanly between edges, and that `vl` is no larger than the element count. Under that assumption a position that did not wrap must lie below the `vl` that was sampled with the step. The stimulus changes inputs only on the falling edge and keeps `vl` within 0..64. It covers full-length and zero-length vectors, sparse masks, masks with only the top bits set, and commands rejected for each wrong flag combination. Loop-state flags are treated as free inputs that need no relation to the positions, so the bench sets them to arbitrary patterns.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
   localparam int SEL_W   = 3;
   localparam int LOOP_W  = 3;
   localparam logic [SEL_W-1:0] SEL_RET_SRC = 3'd5;
   localparam logic [SEL_W-1:0] SEL_RET_DST = 3'd6;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_t;
endpackage

// File: rtl/vfs_next_set.sv
module vfs_next_set #(
   parameter int NELEM = 64,
   localparam int IDXW = $clog2(NELEM),
   localparam int VLW  = $clog2(NELEM + 1)
) (
   input  logic [NELEM-1:0] mask,
   input  logic [IDXW-1:0]  cur,
   input  logic [VLW-1:0]   vl,
   output logic             found,
   output logic [IDXW-1:0]  nxt
);
   logic [NELEM-1:0] qual;

   generate
      for (genvar g = 0; g < NELEM; g++) begin : g_qual
         assign qual[g] = mask[g] && (IDXW'(g) > cur) && (VLW'(g) < vl);
      end
   endgenerate

   always_comb begin
      nxt = '0;
      for (int i = NELEM - 1; i >= 0; i--) begin
         if (qual[i]) nxt = IDXW'(i);
      end
   end

   assign found = |qual;
endmodule

// File: rtl/vfs_cond.sv
module vfs_cond
   import vfs_pkg::*;
#(
   parameter int NSTATE = 4
) (
   input  logic [SEL_W-1:0]         sel,
   input  logic [NSTATE*LOOP_W-1:0] loop_end,
   input  logic                     wrap,
   output cond_t                    cr
);
   logic [LOOP_W-1:0] picked;

   always_comb begin
      picked = '0;
      for (int k = 0; k < NSTATE; k++) begin
         if (sel == SEL_W'(k + 1)) picked = loop_end[k*LOOP_W +: LOOP_W];
      end
      cr.eq = picked[0];
      cr.lt = picked[1];
      cr.gt = picked[2];
      cr.so = wrap;
   end
endmodule

// File: rtl/vfs_stepper.sv
module vfs_stepper
   import vfs_pkg::*;
#(
   parameter int NELEM  = 64,
   parameter int DATA_W = 64,
   parameter int NSTATE = 4,
   localparam int IDXW  = $clog2(NELEM),
   localparam int VLW   = $clog2(NELEM + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [VLW-1:0]           vl,
   input  logic [NELEM-1:0]         src_mask,
   input  logic [NELEM-1:0]         dst_mask,
   input  logic                     step_en,
   input  logic                     vf,
   input  logic                     vs,
   input  logic                     ms,
   input  logic [SEL_W-1:0]         sel,
   input  logic                     rc,
   input  logic                     rt_nz,
   input  logic [NSTATE*LOOP_W-1:0] loop_end,
   output logic [IDXW-1:0]          src_idx,
   output logic [IDXW-1:0]          dst_idx,
   output logic                     vec_end,
   output logic                     cr_valid,
   output logic [3:0]               cr_field,
   output logic                     ret_valid,
   output logic [DATA_W-1:0]        ret_value
);
   initial begin
      if (NELEM < 2 || (1 << IDXW) != NELEM)
         $fatal(1, "NELEM must be a power of two of at least 2");
      if (DATA_W < IDXW)
         $fatal(1, "DATA_W too narrow for an element position");
      if (NSTATE < 1 || NSTATE > 4)
         $fatal(1, "NSTATE must be 1..4 to leave selectors 5 and 6 free");
   end

   logic            accept;
   logic            s_found, d_found, wrap;
   logic [IDXW-1:0] s_nxt, d_nxt, src_new, dst_new;
   cond_t           cr_nxt;
   logic            ret_hit;
   logic [DATA_W-1:0] ret_nxt;

   assign accept = step_en & vf & ~vs & ~ms;

   vfs_next_set #(.NELEM(NELEM)) u_src_find (
      .mask(src_mask), .cur(src_idx), .vl(vl), .found(s_found), .nxt(s_nxt));

   vfs_next_set #(.NELEM(NELEM)) u_dst_find (
      .mask(dst_mask), .cur(dst_idx), .vl(vl), .found(d_found), .nxt(d_nxt));

   assign wrap    = ~(s_found & d_found);
   assign src_new = wrap ? '0 : s_nxt;
   assign dst_new = wrap ? '0 : d_nxt;

   vfs_cond #(.NSTATE(NSTATE)) u_cond (
      .sel(sel), .loop_end(loop_end), .wrap(wrap), .cr(cr_nxt));

   assign ret_hit = rt_nz & ((sel == SEL_RET_SRC) | (sel == SEL_RET_DST));

   generate
      if (DATA_W > IDXW) begin : g_ret_wide
         assign ret_nxt = {{(DATA_W-IDXW){1'b0}},
                           (sel == SEL_RET_SRC) ? src_new : dst_new};
      end else begin : g_ret_exact
         assign ret_nxt = (sel == SEL_RET_SRC) ? src_new : dst_new;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_idx   <= '0;
         dst_idx   <= '0;
         vec_end   <= 1'b0;
         cr_valid  <= 1'b0;
         cr_field  <= '0;
         ret_valid <= 1'b0;
         ret_value <= '0;
      end else begin
         cr_valid  <= accept & rc;
         ret_valid <= accept & ret_hit;
         if (accept) begin
            src_idx <= src_new;
            dst_idx <= dst_new;
            vec_end <= wrap;
            if (rc)      cr_field  <= cr_nxt;
            if (ret_hit) ret_value <= ret_nxt;
         end
      end
   end
endmodule

// File: rtl/vfs_stepper_chk.sv
module vfs_stepper_chk #(
   parameter int NELEM  = 64,
   parameter int DATA_W = 64,
   parameter int NSTATE = 4,
   localparam int IDXW  = $clog2(NELEM),
   localparam int VLW   = $clog2(NELEM + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [VLW-1:0]       vl,
   input logic                 step_en,
   input logic                 vf,
   input logic                 vs,
   input logic                 ms,
   input logic                 rc,
   input logic                 rt_nz,
   input logic [IDXW-1:0]      src_idx,
   input logic [IDXW-1:0]      dst_idx,
   input logic                 vec_end,
   input logic                 cr_valid,
   input logic [3:0]           cr_field,
   input logic                 ret_valid,
   input logic [DATA_W-1:0]    ret_value
);
   logic go;
   assign go = step_en && vf && !vs && !ms;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> ($stable(src_idx) && $stable(dst_idx) && $stable(vec_end))); // R2
   AST_SRC_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (vec_end || (src_idx > $past(src_idx)))); // R3
   AST_DST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (vec_end || (dst_idx > $past(dst_idx)))); // R3
   AST_SRC_BELOW_VL: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (vec_end || ({1'b0, src_idx} < $past(vl)))); // R3
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (go && vl == '0) |=> (vec_end && src_idx == '0 && dst_idx == '0)); // R4
   AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      vec_end |-> (src_idx == '0 && dst_idx == '0)); // R4
   AST_SO_IS_END: assert property (@(posedge clk) disable iff (!rst_n)
      cr_valid |-> (cr_field[0] == vec_end)); // R5
   AST_CR_NEEDS_RC: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && rc) |=> (!cr_valid && $stable(cr_field))); // R8
   AST_RET_NEEDS_RT: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && rt_nz) |=> (!ret_valid && $stable(ret_value))); // R7
   AST_RET_IS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> (ret_value == DATA_W'(src_idx) || ret_value == DATA_W'(dst_idx))); // R7
endmodule

bind vfs_stepper vfs_stepper_chk #(.NELEM(NELEM), .DATA_W(DATA_W), .NSTATE(NSTATE)) u_chk (
   .clk(clk), .rst_n(rst_n), .vl(vl), .step_en(step_en), .vf(vf), .vs(vs), .ms(ms),
   .rc(rc), .rt_nz(rt_nz), .src_idx(src_idx), .dst_idx(dst_idx), .vec_end(vec_end),
   .cr_valid(cr_valid), .cr_field(cr_field), .ret_valid(ret_valid), .ret_value(ret_value));

// File: tb/vfs_stepper_test.sv
module vfs_stepper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  vl = '0;
   logic [63:0] src_mask = '0, dst_mask = '0;
   logic        step_en = 1'b0, vf = 1'b0, vs = 1'b0, ms = 1'b0;
   logic [2:0]  sel = '0;
   logic        rc = 1'b0, rt_nz = 1'b0;
   logic [11:0] loop_end = '0;
   logic [5:0]  src_idx, dst_idx;
   logic        vec_end, cr_valid, ret_valid;
   logic [3:0]  cr_field;
   logic [63:0] ret_value;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vfs_stepper uut (
      .clk(clk), .rst_n(rst_n), .vl(vl), .src_mask(src_mask), .dst_mask(dst_mask),
      .step_en(step_en), .vf(vf), .vs(vs), .ms(ms), .sel(sel), .rc(rc), .rt_nz(rt_nz),
      .loop_end(loop_end), .src_idx(src_idx), .dst_idx(dst_idx), .vec_end(vec_end),
      .cr_valid(cr_valid), .cr_field(cr_field), .ret_valid(ret_valid), .ret_value(ret_value));

   typedef struct packed {
      logic [6:0]  vl;
      logic [63:0] sm;
      logic [63:0] dm;
      logic [2:0]  sel;
      logic        rc;
      logic        rtnz;
      logic [11:0] le;
      logic [5:0]  e_src;
      logic [5:0]  e_dst;
      logic        e_end;
      logic        e_crv;
      logic [3:0]  e_cr;
      logic        e_retv;
      logic [5:0]  e_ret;
   } vec_t;

   localparam logic [63:0] SM_A = 64'h0000_0000_0000_00B5; // bits 0,2,4,5,7
   localparam logic [63:0] DM_A = 64'h0000_0000_0000_002A; // bits 1,3,5
   localparam logic [63:0] SM_B = 64'h8000_0000_0000_0001;
   localparam logic [63:0] DM_B = 64'h4000_0000_0000_0000;

   localparam vec_t TBL [9] = '{
      '{7'd8,  SM_A, DM_A, 3'd1, 1'b1, 1'b0, 12'h005, 6'd2,  6'd1,  1'b0, 1'b1, 4'h6, 1'b0, 6'd0},
      '{7'd8,  SM_A, DM_A, 3'd5, 1'b0, 1'b1, 12'h000, 6'd4,  6'd3,  1'b0, 1'b0, 4'h6, 1'b1, 6'd4},
      '{7'd8,  SM_A, DM_A, 3'd6, 1'b1, 1'b1, 12'hFFF, 6'd5,  6'd5,  1'b0, 1'b1, 4'h0, 1'b1, 6'd5},
      '{7'd8,  SM_A, DM_A, 3'd3, 1'b1, 1'b0, 12'h0C0, 6'd0,  6'd0,  1'b1, 1'b1, 4'hB, 1'b0, 6'd5},
      '{7'd8,  SM_A, DM_A, 3'd5, 1'b0, 1'b0, 12'h000, 6'd2,  6'd1,  1'b0, 1'b0, 4'hB, 1'b0, 6'd5},
      '{7'd3,  SM_A, DM_A, 3'd2, 1'b1, 1'b0, 12'h038, 6'd0,  6'd0,  1'b1, 1'b1, 4'hF, 1'b0, 6'd5},
      '{7'd64, SM_B, DM_B, 3'd6, 1'b1, 1'b1, 12'hE00, 6'd63, 6'd62, 1'b0, 1'b1, 4'h0, 1'b1, 6'd62},
      '{7'd64, SM_B, DM_B, 3'd4, 1'b1, 1'b0, 12'hE00, 6'd0,  6'd0,  1'b1, 1'b1, 4'hF, 1'b0, 6'd62},
      '{7'd0,  SM_A, DM_A, 3'd7, 1'b1, 1'b1, 12'hFFF, 6'd0,  6'd0,  1'b1, 1'b1, 4'h1, 1'b0, 6'd62}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic v_vf, input logic v_vs, input logic v_ms);
      @(negedge clk);
      step_en = 1'b1; vf = v_vf; vs = v_vs; ms = v_ms;
      @(posedge clk); #1;
      @(negedge clk);
      step_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(src_idx == 0 && dst_idx == 0, "R1 idx", {src_idx, dst_idx}, 0);
      chk(!vec_end && !cr_valid && !ret_valid && cr_field == 0 && ret_value == 0,
          "R1 flags", {vec_end, cr_valid, ret_valid, cr_field}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(src_idx == 0 && dst_idx == 0 && !vec_end, "R1 after release", {src_idx, dst_idx}, 0);

      // table walk: drive at negedge, sample after the stepping edge
      foreach (TBL[i]) begin
         @(negedge clk);
         vl = TBL[i].vl; src_mask = TBL[i].sm; dst_mask = TBL[i].dm;
         sel = TBL[i].sel; rc = TBL[i].rc; rt_nz = TBL[i].rtnz; loop_end = TBL[i].le;
         step_en = 1'b1; vf = 1'b1; vs = 1'b0; ms = 1'b0;
         @(posedge clk); #1;
         chk(src_idx == TBL[i].e_src, "R3 src step", src_idx, TBL[i].e_src);
         chk(dst_idx == TBL[i].e_dst, "R3 dst step", dst_idx, TBL[i].e_dst);
         chk(vec_end == TBL[i].e_end, "R4 end flag", vec_end, TBL[i].e_end);
         chk(cr_valid == TBL[i].e_crv, "R5 cr pulse", cr_valid, TBL[i].e_crv);
         chk(cr_field == TBL[i].e_cr, "R6 cr field", cr_field, TBL[i].e_cr);
         chk(ret_valid == TBL[i].e_retv, "R7 ret pulse", ret_valid, TBL[i].e_retv);
         chk(ret_value == 64'(TBL[i].e_ret), "R7 ret value", ret_value, 64'(TBL[i].e_ret));
         @(negedge clk);
         step_en = 1'b0;
         @(posedge clk); #1;
         chk(!cr_valid && !ret_valid, "R5 R7 pulse width", {cr_valid, ret_valid}, 0);
         chk(src_idx == TBL[i].e_src && dst_idx == TBL[i].e_dst, "R2 hold idle",
             {src_idx, dst_idx}, {TBL[i].e_src, TBL[i].e_dst});
      end

      // R2/R8: rejected commands leave everything unchanged
      vl = 7'd8; src_mask = SM_A; dst_mask = DM_A; rc = 1'b1; rt_nz = 1'b1; sel = 3'd5;
      loop_end = 12'hFFF;
      issue(1'b1, 1'b1, 1'b0);
      chk(src_idx == 0 && dst_idx == 0, "R2 vs=1 rejected", {src_idx, dst_idx}, 0);
      chk(!cr_valid && !ret_valid && cr_field == 4'h1, "R8 no update vs=1",
          {cr_valid, ret_valid, cr_field}, 4'h1);
      issue(1'b1, 1'b0, 1'b1);
      chk(src_idx == 0 && dst_idx == 0, "R2 ms=1 rejected", {src_idx, dst_idx}, 0);
      issue(1'b0, 1'b0, 1'b0);
      chk(src_idx == 0 && dst_idx == 0 && ret_value == 64'd62, "R8 vf=0 rejected",
          {src_idx, ret_value[5:0]}, 62);
      chk(vec_end == 1'b1, "R4 end held on reject", vec_end, 1);

      // accepted step after rejects, then reset mid-run
      issue(1'b1, 1'b0, 1'b0);
      chk(src_idx == 6'd2 && dst_idx == 6'd1 && !vec_end, "R3 step after reject",
          {src_idx, dst_idx}, {6'd2, 6'd1});
      chk(ret_value == 64'd2, "R7 src returned", ret_value, 2);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(src_idx == 0 && dst_idx == 0 && cr_field == 0 && ret_value == 0, "R1 reset mid-run",
          {src_idx, dst_idx}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule